// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog Timer

This block is a free-running watchdog driven by a 32.768 kHz low-speed clock. Software must strobe the kick input before the selected period runs out. If the period runs out once, the block sends a one-cycle non-maskable interrupt request and raises a warning flag. This gives software one more period to recover. If the period runs out again with no kick in between, the block raises a system reset request. That request stays high until the block's own synchronous reset is applied.

The timeout is chosen by a 2-bit code. The block latches the code only at reset or at a kick, so a period already running is never shortened or stretched partway through. The default terminal counts are 4096, 16384, 65536 and 262144 clock cycles, which at 32.768 kHz give 125 ms, 500 ms, 2 s and 8 s. Software has no way to stop the counter.

Top module: `wdog_two_stage`

## Requirements
- R1: While `rst` is high at a clock edge, the counter returns to zero and the stage returns to "no overflow". After that edge `nmi_req`, `warn_flag` and `reset_req` are all low, and `period_sel` is latched.
- R2: Latched code c (0 to 3) sets the timeout to 2^(BASE_LOG2 + 2*c) clock cycles. With the default BASE_LOG2 = 12 this gives 4096, 16384, 65536 and 262144 cycles.
- R3: The first expiry after a reset or kick sets `nmi_req` high for exactly one cycle. It is seen after the T-th edge counted from the origin, where T is the timeout.
- R4: `warn_flag` rises together with that first `nmi_req` pulse. It stays high until a kick or a reset.
- R5: A second expiry with no kick since the first raises `reset_req`. This happens after edge 2*T counted from the origin.
- R6: A kick restarts the count from zero, lowers `warn_flag` and returns the stage to "no overflow". A kick on the same edge where an expiry would happen wins, and no pulse is issued.
- R7: Once `reset_req` is high it stays high, and kicks do not lower it. Only `rst` clears it.
- R8: A change on `period_sel` has no effect on the period already running. The new code is taken at the next kick.
- R9: While `reset_req` is high, no further `nmi_req` pulse is issued, whatever the count does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-speed timer clock |
| rst | input | 1 | Synchronous reset, active high |
| period_sel | input | SEL_W | Timeout code, latched at reset or kick |
| kick | input | 1 | Clear strobe, one cycle |
| nmi_req | output | 1 | One-cycle non-maskable interrupt request |
| reset_req | output | 1 | Sticky system reset request |
| warn_flag | output | 1 | Sticky first-expiry status |

## Verification
The bench elaborates a small configuration (BASE_LOG2 = 3). This gives terminal counts of 8, 32, 128 and 512, and all four codes are run uninterrupted through both expiries and beyond. That run separates the correct period decode from an off-by-one count and from an escalation that skips the warning stage. A kick is placed mid-warning and another exactly on the expiry edge, which tells apart correct clear priority from a wrap that slips through. A run of kicks after the reset request shows that the request is sticky. A code change partway through a period, followed by a kick, shows whether the code is latched or read live.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   typedef enum logic [1:0] {
      ST_CALM    = 2'd0,
      ST_WARNED  = 2'd1,
      ST_TRIPPED = 2'd2
   } wd_stage_e;

   function automatic int unsigned wd_cnt_width(input int unsigned base_log2,
                                                input int unsigned step_log2,
                                                input int unsigned sel_w);
      return base_log2 + step_log2 * ((1 << sel_w) - 1);
   endfunction

endpackage

// File: rtl/wdog_period_dec.sv
module wdog_period_dec #(
   parameter int unsigned SEL_W     = 2,
   parameter int unsigned BASE_LOG2 = 12,
   parameter int unsigned STEP_LOG2 = 2,
   parameter int unsigned CNT_W     = 18
) (
   input  logic [SEL_W-1:0] code,
   output logic [CNT_W-1:0] last_cnt
);
   localparam int unsigned NCODE = 1 << SEL_W;

   logic [CNT_W-1:0] lim_tab [NCODE];

   for (genvar i = 0; i < NCODE; i++) begin : g_lim
      localparam int unsigned SH = BASE_LOG2 + STEP_LOG2 * i;
      if (SH > CNT_W) begin : g_bad
         $error("period exponent exceeds counter width");
      end
      assign lim_tab[i] = {CNT_W{1'b1}} >> (CNT_W - SH);
   end

   assign last_cnt = lim_tab[code];

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
   parameter int unsigned SEL_W     = 2,
   parameter int unsigned BASE_LOG2 = 12,
   parameter int unsigned STEP_LOG2 = 2,
   parameter int unsigned CNT_W     = 18
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             kick,
   input  logic [SEL_W-1:0] period_sel,
   output logic             wrap
);
   logic [CNT_W-1:0] cnt_q;
   logic [SEL_W-1:0] sel_q;
   logic [CNT_W-1:0] last_cnt;
   logic             at_end;

   wdog_period_dec #(
      .SEL_W    (SEL_W),
      .BASE_LOG2(BASE_LOG2),
      .STEP_LOG2(STEP_LOG2),
      .CNT_W    (CNT_W)
   ) u_dec (
      .code    (sel_q),
      .last_cnt(last_cnt)
   );

   assign at_end = (cnt_q == last_cnt);
   assign wrap   = at_end && !kick;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         sel_q <= period_sel;
      end else if (kick) begin
         cnt_q <= '0;
         sel_q <= period_sel;
      end else if (at_end) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R2: count never passes the decoded terminal value
   p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= last_cnt);

   // R6: a kick restarts the count
   p_kick_restart_r6: assert property (@(posedge clk) disable iff (rst)
      kick |=> (cnt_q == '0));

   // R8: latched code only moves on a kick
   p_sel_hold_r8: assert property (@(posedge clk) disable iff (rst)
      !kick |=> $stable(sel_q));

endmodule

// File: rtl/wdog_stage_fsm.sv
module wdog_stage_fsm
   import wdog_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic kick,
   input  logic wrap,
   output logic nmi_req,
   output logic reset_req,
   output logic warn_flag
);
   wd_stage_e stage_q, stage_d;
   logic      nmi_q, nmi_d;

   always_comb begin
      stage_d = stage_q;
      nmi_d   = 1'b0;
      if (stage_q == ST_TRIPPED) begin
         stage_d = ST_TRIPPED;
      end else if (kick) begin
         stage_d = ST_CALM;
      end else if (wrap) begin
         if (stage_q == ST_CALM) begin
            stage_d = ST_WARNED;
            nmi_d   = 1'b1;
         end else begin
            stage_d = ST_TRIPPED;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         stage_q <= ST_CALM;
         nmi_q   <= 1'b0;
      end else begin
         stage_q <= stage_d;
         nmi_q   <= nmi_d;
      end
   end

   assign nmi_req   = nmi_q;
   assign reset_req = (stage_q == ST_TRIPPED);
   assign warn_flag = (stage_q != ST_CALM);

   // R3: interrupt request is a single-cycle pulse
   p_nmi_single_r3: assert property (@(posedge clk) disable iff (rst)
      nmi_req |=> !nmi_req);

   // R4: pulse is accompanied by the warning flag
   p_nmi_flag_r4: assert property (@(posedge clk) disable iff (rst)
      nmi_req |-> warn_flag);

   // R5: reset request only follows a warned stage
   p_rst_after_warn_r5: assert property (@(posedge clk) disable iff (rst)
      $rose(reset_req) |-> $past(warn_flag));

   // R6: a kick outside the tripped stage clears the warning
   p_kick_clears_r6: assert property (@(posedge clk) disable iff (rst)
      (kick && !reset_req) |=> !warn_flag);

   // R7: reset request is sticky
   p_rst_sticky_r7: assert property (@(posedge clk) disable iff (rst)
      reset_req |=> reset_req);

   // R9: no interrupt pulse after tripping
   p_no_nmi_tripped_r9: assert property (@(posedge clk) disable iff (rst)
      reset_req |=> !nmi_req);

endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage #(
   parameter int unsigned SEL_W     = 2,
   parameter int unsigned BASE_LOG2 = 12,
   parameter int unsigned STEP_LOG2 = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [SEL_W-1:0] period_sel,
   input  logic             kick,
   output logic             nmi_req,
   output logic             reset_req,
   output logic             warn_flag
);
   localparam int unsigned CNT_W =
      wdog_pkg::wd_cnt_width(BASE_LOG2, STEP_LOG2, SEL_W);

   if (SEL_W < 1 || SEL_W > 3) begin : g_chk_sel
      $error("SEL_W must be 1..3");
   end
   if (BASE_LOG2 < 1) begin : g_chk_base
      $error("BASE_LOG2 must be at least 1");
   end
   if (STEP_LOG2 < 1) begin : g_chk_step
      $error("STEP_LOG2 must be at least 1");
   end
   if (CNT_W > 40) begin : g_chk_w
      $error("counter width too large");
   end

   logic wrap;

   wdog_counter #(
      .SEL_W    (SEL_W),
      .BASE_LOG2(BASE_LOG2),
      .STEP_LOG2(STEP_LOG2),
      .CNT_W    (CNT_W)
   ) u_cnt (
      .clk       (clk),
      .rst       (rst),
      .kick      (kick),
      .period_sel(period_sel),
      .wrap      (wrap)
   );

   wdog_stage_fsm u_fsm (
      .clk      (clk),
      .rst      (rst),
      .kick     (kick),
      .wrap     (wrap),
      .nmi_req  (nmi_req),
      .reset_req(reset_req),
      .warn_flag(warn_flag)
   );

   // R1: outputs quiet on the cycle after reset
   p_reset_quiet_r1: assert property (@(posedge clk)
      $past(rst) |-> !(nmi_req || reset_req || warn_flag));

endmodule

// File: tb/wdog_two_stage_tb_top.sv
module wdog_two_stage_tb_top;
   localparam int unsigned BASE = 3;

   logic       clk = 1'b0;
   logic       rst = 1'b0;
   logic [1:0] period_sel = '0;
   logic       kick = 1'b0;
   logic       nmi_req, reset_req, warn_flag;

   int checks = 0;
   int fails  = 0;

   int e;
   int cur_tc;
   bit locked;

   always #2 clk = ~clk;

   wdog_two_stage #(.SEL_W(2), .BASE_LOG2(BASE), .STEP_LOG2(2)) dut_i (
      .clk(clk), .rst(rst), .period_sel(period_sel), .kick(kick),
      .nmi_req(nmi_req), .reset_req(reset_req), .warn_flag(warn_flag)
   );

   function automatic int tc_of(input logic [1:0] c);
      return 1 << (BASE + 2 * c);
   endfunction

   task automatic check(input string tag, input logic [2:0] got, input logic [2:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: {nmi,warn,rst_req} got=%b exp=%b (e=%0d tc=%0d)",
                  tag, got, exp, e, cur_tc);
      end
   endtask

   // R1: reset state after a synchronous reset edge
   task automatic do_reset(input logic [1:0] c);
      period_sel = c;
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      e = 0;
      cur_tc = tc_of(c);
      locked = 0;
      check("R1", {nmi_req, warn_flag, reset_req}, 3'b000);
   endtask

   task automatic tick(input string tag, input logic k);
      logic [2:0] exp;
      logic [1:0] sel_at_edge;
      kick = k;
      sel_at_edge = period_sel;
      @(posedge clk);
      @(negedge clk);
      kick = 1'b0;
      if (!locked) begin
         if (k) begin
            e = 0;
            cur_tc = tc_of(sel_at_edge);
         end else begin
            e++;
         end
      end
      if (locked) exp = 3'b011;
      else exp = {e == cur_tc, e >= cur_tc, e >= 2 * cur_tc};
      if (!locked && e >= 2 * cur_tc) locked = 1;
      check(tag, {nmi_req, warn_flag, reset_req}, exp);
   endtask

   initial begin
      #800000;
      fails++;
      $display("FAIL watchdog: run did not end, got=hung exp=done");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
   end

   initial begin
      @(negedge clk);
      // R2 R3 R4 R5 R9: every code, uninterrupted, well past the trip
      for (int c = 0; c < 4; c++) begin
         do_reset(2'(c));
         for (int i = 0; i < 4 * tc_of(2'(c)); i++) begin
            if (i < tc_of(2'(c))) tick("R2", 1'b0);
            else if (i < 2 * tc_of(2'(c))) tick("R4", 1'b0);
            else if (i == 2 * tc_of(2'(c)) - 1 + 1) tick("R5", 1'b0);
            else tick("R9", 1'b0);
         end
      end

      // R6: kick while warned, then a kick on the expiry edge
      do_reset(2'd1);
      for (int i = 0; i < 37; i++) tick("R3", 1'b0);
      tick("R6", 1'b1);
      for (int i = 0; i < 31; i++) tick("R6", 1'b0);
      tick("R6", 1'b1);
      for (int i = 0; i < 70; i++) tick("R6", 1'b0);

      // R7: kicks after the trip leave the request high; reset clears it
      do_reset(2'd0);
      for (int i = 0; i < 16; i++) tick("R5", 1'b0);
      for (int i = 0; i < 20; i++) tick("R7", i[0]);
      do_reset(2'd0);
      for (int i = 0; i < 10; i++) tick("R7", 1'b0);

      // R8: code change mid-period is ignored until the next kick
      do_reset(2'd0);
      for (int i = 0; i < 3; i++) tick("R8", 1'b0);
      period_sel = 2'd2;
      for (int i = 0; i < 7; i++) tick("R8", 1'b0);
      tick("R8", 1'b1);
      for (int i = 0; i < 260; i++) tick("R8", 1'b0);

      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
   end

endmodule